// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps two predictors and a chooser. The first predictor keeps a separate outcome history for each branch and uses that history to pick a 3-bit counter. The second predictor uses a global register of recent branch outcomes to pick a 2-bit counter. A table of 2-bit chooser counters, indexed by the same global history, decides for each lookup which of the two predictors supplies the final answer.

The front end presents a fetch address index on the lookup port and gets back a combinational answer in the same cycle. It also gets both sub-predictions and the global history that the lookup used. Each accepted lookup shifts the predicted direction into the global history at once. Later, the back end returns the real outcome on the training port, together with the two sub-predictions and the history snapshot it kept. When the branch was mispredicted, the global history is rebuilt from that snapshot plus the real outcome.

Table sizes and counter widths are parameters. By default the block has a 1024 x 10-bit per-branch history table, 1024 3-bit local counters, 4096 2-bit global counters and 4096 2-bit chooser counters.

Top module: `tbp_tournament`

## Requirements
- R1: After reset, every local counter is 3 (weakly not-taken, 3-bit), every global counter is 1 (weakly not-taken), every chooser counter is 1 (weakly prefers local), and all histories are zero. The first lookup therefore reports not-taken, local selected and a global history of 0.
- R2: The per-branch history table is indexed by the fetch address index (address bits [11:2]). On a training event, the real outcome shifts into bit 0 of the history for that branch. The local counter is selected by that branch's history, not by its address, so two branches with equal histories share one counter.
- R3: The local sub-prediction is the most significant bit of the 3-bit counter selected by the branch's current history. On training, the counter picked by the branch's history before the shift moves one step toward the outcome.
- R4: The global sub-prediction is the MSB of the 2-bit counter at the current global history. On training, the counter at the supplied snapshot moves one step toward the outcome.
- R5: A chooser counter with MSB 1 selects the global sub-prediction, and MSB 0 selects the local one. On training, the counter at the snapshot changes only when the two supplied sub-predictions differ. It counts up when the global one matched the outcome and down when the local one did.
- R6: The final prediction equals the sub-prediction that the chooser selects.
- R7: An accepted lookup shifts the final prediction into bit 0 of the global history on the next edge. The history output shows the value the lookup used, before that shift. Without a lookup or a restore, the history holds its value.
- R8: A training event flagged as mispredicted loads the global history with the snapshot shifted left by one, with the real outcome in bit 0. This restore overrides a same-cycle lookup shift.
- R9: Counters saturate at 0 and at their maximum, and they never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup accepted this cycle |
| lk_pc_idx | input | LHT_IDX_W | Fetch address bits [11:2] of the branch looked up |
| lk_taken | output | 1 | Final direction prediction |
| lk_local | output | 1 | Local sub-prediction |
| lk_global | output | 1 | Global sub-prediction |
| lk_use_global | output | 1 | Chooser selects the global sub-prediction |
| lk_ghist | output | GHIST_W | Global history used by this lookup (snapshot to keep) |
| tr_valid | input | 1 | Training event this cycle |
| tr_pc_idx | input | LHT_IDX_W | Address bits [11:2] of the resolved branch |
| tr_taken | input | 1 | Real outcome |
| tr_local | input | 1 | Local sub-prediction recorded at lookup |
| tr_global | input | 1 | Global sub-prediction recorded at lookup |
| tr_mispredict | input | 1 | Final prediction was wrong; restore history |
| tr_ghist | input | GHIST_W | History snapshot recorded at lookup |

## Verification
The history properties assume that inputs are known whenever lookup or training is valid. They also assume that the lookup and training strobes stay low while reset is asserted, because the first cycle after release is compared with the one before it. The stimulus drives both strobes low during every reset. It only ever returns sub-predictions and snapshots that the block reported on an earlier lookup. It also drops the lookup in a restore cycle, so that the snapshots it returns stay consistent, except in one directed case that checks that the restore wins over a same-cycle shift.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
   typedef enum logic {
      SEL_LOCAL  = 1'b0,
      SEL_GLOBAL = 1'b1
   } tbp_sel_e;

   // weakly-not-taken value of an n-bit counter: 2^(n-1)-1
   function automatic int unsigned weak_nt(input int unsigned w);
      return (1 << (w - 1)) - 1;
   endfunction
endpackage

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table #(
   parameter int unsigned IDX_W   = 10,
   parameter int unsigned CTR_W   = 3,
   parameter int unsigned RST_VAL = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_msb,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_up
);
   localparam int unsigned DEPTH = 1 << IDX_W;
   localparam logic [CTR_W-1:0] CMAX = '1;
   localparam logic [CTR_W-1:0] CRST = CTR_W'(RST_VAL);

   if (CTR_W < 2 || RST_VAL > (1 << CTR_W) - 1) begin : g_bad_cfg
      $error("tbp_ctr_table: bad counter width or reset value");
   end

   logic [CTR_W-1:0] mem [DEPTH];
   logic [CTR_W-1:0] rd_val;
   logic [CTR_W-1:0] cur;
   logic [CTR_W-1:0] nxt;

   assign rd_val = mem[rd_idx];
   assign rd_msb = rd_val[CTR_W-1];

   always_comb begin
      cur = mem[wr_idx];
      nxt = cur;
      if (wr_up && cur != CMAX)
         nxt = cur + 1'b1;
      else if (!wr_up && cur != '0)
         nxt = cur - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= CRST;
      end else if (wr_en) begin
         mem[wr_idx] <= nxt;
      end
   end
endmodule

// File: rtl/tbp_hist_table.sv
module tbp_hist_table #(
   parameter int unsigned IDX_W  = 10,
   parameter int unsigned HIST_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [HIST_W-1:0] rd_hist,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_bit,
   output logic [HIST_W-1:0] wr_hist_cur
);
   localparam int unsigned DEPTH = 1 << IDX_W;

   if (HIST_W < 2) begin : g_bad_cfg
      $error("tbp_hist_table: history must be at least 2 bits");
   end

   logic [HIST_W-1:0] mem [DEPTH];

   assign rd_hist     = mem[rd_idx];
   assign wr_hist_cur = mem[wr_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en) begin
         mem[wr_idx] <= {wr_hist_cur[HIST_W-2:0], wr_bit};
      end
   end
endmodule

// File: rtl/tbp_ghr.sv
module tbp_ghr #(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         spec_en,
   input  logic         spec_bit,
   input  logic         fix_en,
   input  logic [W-1:0] fix_snap,
   input  logic         fix_bit,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (fix_en)
         q <= {fix_snap[W-2:0], fix_bit};
      else if (spec_en)
         q <= {q[W-2:0], spec_bit};
   end
endmodule

// File: rtl/tbp_tournament.sv
module tbp_tournament
   import tbp_pkg::*;
#(
   parameter int unsigned LHT_IDX_W = 10,
   parameter int unsigned LHIST_W   = 10,
   parameter int unsigned LCTR_W    = 3,
   parameter int unsigned GHIST_W   = 12,
   parameter int unsigned GCTR_W    = 2,
   parameter int unsigned CCTR_W    = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 lk_valid,
   input  logic [LHT_IDX_W-1:0] lk_pc_idx,
   output logic                 lk_taken,
   output logic                 lk_local,
   output logic                 lk_global,
   output logic                 lk_use_global,
   output logic [GHIST_W-1:0]   lk_ghist,
   input  logic                 tr_valid,
   input  logic [LHT_IDX_W-1:0] tr_pc_idx,
   input  logic                 tr_taken,
   input  logic                 tr_local,
   input  logic                 tr_global,
   input  logic                 tr_mispredict,
   input  logic [GHIST_W-1:0]   tr_ghist
);
   localparam int unsigned L_RST = weak_nt(LCTR_W);
   localparam int unsigned G_RST = weak_nt(GCTR_W);
   localparam int unsigned C_RST = weak_nt(CCTR_W);

   if (LHT_IDX_W < 1 || LHIST_W < 2 || GHIST_W < 2) begin : g_bad_cfg
      $error("tbp_tournament: index or history width too small");
   end

   logic [LHIST_W-1:0] lk_lhist;
   logic [LHIST_W-1:0] tr_lhist;
   logic [GHIST_W-1:0] ghr_q;
   logic               sub_local;
   logic               sub_global;
   logic               choice_msb;
   tbp_sel_e           sel;
   logic               choice_train;
   logic               restore;

   // per-branch history: read for lookup, shift on training
   tbp_hist_table #(.IDX_W(LHT_IDX_W), .HIST_W(LHIST_W)) u_lht (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(lk_pc_idx), .rd_hist(lk_lhist),
      .wr_en(tr_valid), .wr_idx(tr_pc_idx), .wr_bit(tr_taken),
      .wr_hist_cur(tr_lhist)
   );

   // local counters, indexed by branch history
   tbp_ctr_table #(.IDX_W(LHIST_W), .CTR_W(LCTR_W), .RST_VAL(L_RST)) u_lct (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(lk_lhist), .rd_msb(sub_local),
      .wr_en(tr_valid), .wr_idx(tr_lhist), .wr_up(tr_taken)
   );

   // global counters, indexed by global history
   tbp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(GCTR_W), .RST_VAL(G_RST)) u_gct (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(ghr_q), .rd_msb(sub_global),
      .wr_en(tr_valid), .wr_idx(tr_ghist), .wr_up(tr_taken)
   );

   // chooser trains only on disagreement, toward the correct side
   assign choice_train = tr_valid && (tr_local != tr_global);

   tbp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(CCTR_W), .RST_VAL(C_RST)) u_cct (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(ghr_q), .rd_msb(choice_msb),
      .wr_en(choice_train), .wr_idx(tr_ghist), .wr_up(tr_global == tr_taken)
   );

   assign sel = choice_msb ? SEL_GLOBAL : SEL_LOCAL;

   always_comb begin
      unique case (sel)
         SEL_GLOBAL: lk_taken = sub_global;
         default:    lk_taken = sub_local;
      endcase
   end

   assign restore = tr_valid && tr_mispredict;

   tbp_ghr #(.W(GHIST_W)) u_ghr (
      .clk(clk), .rst_n(rst_n),
      .spec_en(lk_valid), .spec_bit(lk_taken),
      .fix_en(restore), .fix_snap(tr_ghist), .fix_bit(tr_taken),
      .q(ghr_q)
   );

   assign lk_local      = sub_local;
   assign lk_global     = sub_global;
   assign lk_use_global = (sel == SEL_GLOBAL);
   assign lk_ghist      = ghr_q;
endmodule

// File: rtl/tbp_tournament_chk.sv
module tbp_tournament_chk #(
   parameter int unsigned GHIST_W = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic               lk_valid,
   input logic               lk_taken,
   input logic [GHIST_W-1:0] lk_ghist,
   input logic               tr_valid,
   input logic               tr_taken,
   input logic               tr_mispredict,
   input logic [GHIST_W-1:0] tr_ghist
);
   // R7: lookup without restore shifts the predicted direction in
   p_spec_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && !(tr_valid && tr_mispredict)) |=>
      (lk_ghist == {$past(lk_ghist[GHIST_W-2:0]), $past(lk_taken)}));

   // R7: idle cycle holds the history
   p_hist_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!lk_valid && !(tr_valid && tr_mispredict)) |=> $stable(lk_ghist));

   // R8: restore from snapshot, overriding any lookup
   p_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tr_valid && tr_mispredict) |=>
      (lk_ghist == {$past(tr_ghist[GHIST_W-2:0]), $past(tr_taken)}));

   // R6: final prediction is always a known value out of reset
   p_known_pred_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown({lk_taken, lk_ghist}));
endmodule

bind tbp_tournament tbp_tournament_chk #(.GHIST_W(GHIST_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_taken(lk_taken),
   .lk_ghist(lk_ghist), .tr_valid(tr_valid), .tr_taken(tr_taken),
   .tr_mispredict(tr_mispredict), .tr_ghist(tr_ghist)
);

// File: tb/tbp_tournament_tb.sv
`timescale 1ns/1ps
module tbp_tournament_tb;
   localparam int LI = 10, LH = 10, GH = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lk_valid = 1'b0;
   logic [LI-1:0] lk_pc_idx = '0;
   logic          lk_taken, lk_local, lk_global, lk_use_global;
   logic [GH-1:0] lk_ghist;
   logic          tr_valid = 1'b0;
   logic [LI-1:0] tr_pc_idx = '0;
   logic          tr_taken = 1'b0, tr_local = 1'b0, tr_global = 1'b0;
   logic          tr_mispredict = 1'b0;
   logic [GH-1:0] tr_ghist = '0;

   always #2 clk = ~clk;

   tbp_tournament u_dut (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_pc_idx(lk_pc_idx),
      .lk_taken(lk_taken), .lk_local(lk_local), .lk_global(lk_global),
      .lk_use_global(lk_use_global), .lk_ghist(lk_ghist),
      .tr_valid(tr_valid), .tr_pc_idx(tr_pc_idx), .tr_taken(tr_taken),
      .tr_local(tr_local), .tr_global(tr_global),
      .tr_mispredict(tr_mispredict), .tr_ghist(tr_ghist)
   );

   int checks = 0;
   int failures = 0;

   // reference model state
   int m_lh [1024];
   int m_lc [1024];
   int m_gc [4096];
   int m_cc [4096];
   int m_ghr;

   // expected and observed values of the last lookup
   int e_loc, e_glb, e_sel, e_tk, e_gh;
   int d_loc, d_glb, d_sel, d_tk, d_gh;

   function automatic int sat(input int v, input bit up, input int mx);
      if (up) return (v == mx) ? v : v + 1;
      return (v == 0) ? 0 : v - 1;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 1024; i++) begin m_lh[i] = 0; m_lc[i] = 3; end
      for (int i = 0; i < 4096; i++) begin m_gc[i] = 1; m_cc[i] = 1; end
      m_ghr = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; lk_valid = 1'b0; tr_valid = 1'b0; tr_mispredict = 1'b0;
      repeat (3) @(negedge clk);
      model_reset();
      rst_n = 1'b1;
   endtask

   task automatic step(input bit pv, input int ppc, input bit uv, input int upc,
                       input bit ut, input bit ul, input bit ug, input bit um,
                       input int ugh, input bit after_fix);
      int h;
      @(negedge clk);
      lk_valid = pv; lk_pc_idx = LI'(ppc);
      tr_valid = uv; tr_pc_idx = LI'(upc); tr_taken = ut;
      tr_local = ul; tr_global = ug; tr_mispredict = um; tr_ghist = GH'(ugh);
      #1;
      e_loc = (m_lc[m_lh[ppc]] >> 2) & 1;
      e_glb = (m_gc[m_ghr] >> 1) & 1;
      e_sel = (m_cc[m_ghr] >> 1) & 1;
      e_tk  = e_sel ? e_glb : e_loc;
      e_gh  = m_ghr;
      d_loc = int'(lk_local); d_glb = int'(lk_global);
      d_sel = int'(lk_use_global); d_tk = int'(lk_taken); d_gh = int'(lk_ghist);
      if (pv) begin
         chk("R3 local sub-prediction", d_loc, e_loc);
         chk("R4 global sub-prediction", d_glb, e_glb);
         chk("R5 chooser select", d_sel, e_sel);
         chk("R6 final prediction", d_tk, e_tk);
         chk(after_fix ? "R8 restored history" : "R7 history snapshot", d_gh, e_gh);
      end
      @(posedge clk);
      if (uv) begin
         h = m_lh[upc];
         m_lc[h] = sat(m_lc[h], ut, 7);
         m_lh[upc] = ((h << 1) | int'(ut)) & 32'h3FF;
         m_gc[ugh] = sat(m_gc[ugh], ut, 3);
         if (ul != ug) m_cc[ugh] = sat(m_cc[ugh], ug == ut, 3);
      end
      if (uv && um) m_ghr = ((ugh << 1) | int'(ut)) & 32'hFFF;
      else if (pv)  m_ghr = ((m_ghr << 1) | e_tk) & 32'hFFF;
   endtask

   initial begin
      #(4 * 150000);
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int pool [16];
      int cnt [16];
      bit has_p, p_tk, p_pred, p_l, p_g, fixed;
      int p_pc, p_gh, ci, cur_pc;
      bit cur_tk, need_new, pv, um;
      void'($urandom(32'd1234));
      model_reset();
      do_reset();

      // R1: reset state seen through a first lookup
      step(1, 'h040, 0, 0, 0, 0, 0, 0, 0, 0);
      chk("R1 reset prediction", d_tk, 0);
      chk("R1 reset chooser", d_sel, 0);
      chk("R1 reset history", d_gh, 0);
      chk("R1 reset local ctr", d_loc, 0);

      // training only, branch X always taken, then one not-taken
      for (int i = 0; i < 20; i++) step(0, 0, 1, 'h040, 1, 0, 1, 0, 0, 0);
      step(0, 0, 1, 'h040, 0, 1, 1, 0, 0, 0);
      // branch Y with zero history reads the counter X trained at history 0
      step(1, 'h055, 0, 0, 0, 0, 0, 0, 0, 0);
      chk("R2 shared local ctr by history", d_loc, 1);
      chk("R9 global ctr no wrap", d_glb, 1);
      chk("R5 chooser saturated global", d_sel, 1);
      chk("R6 final follows global", d_tk, 1);
      // branch X now has history 3FE, an untouched counter
      step(1, 'h040, 0, 0, 0, 0, 0, 0, 0, 0);
      chk("R2 per-branch history", d_loc, 0);
      chk("R7 speculative shift", d_gh, 1);
      chk("R5 chooser at new history", d_sel, 0);

      // R8: restore beats a same-cycle lookup
      step(1, 'h055, 1, 'h100, 1, 0, 0, 1, 'hABC, 0);
      step(1, 'h055, 0, 0, 0, 0, 0, 0, 0, 1);
      chk("R8 restore value", d_gh, 'h579);

      // random branch stream, one-behind training
      for (int i = 0; i < 16; i++) begin
         pool[i] = (i * 37 + 5) & 'h3FF; cnt[i] = 0;
      end
      has_p = 0; fixed = 0; need_new = 1; cur_pc = 0; cur_tk = 0;
      p_pc = 0; p_tk = 0; p_pred = 0; p_l = 0; p_g = 0; p_gh = 0;
      for (int it = 0; it < 4000; it++) begin
         if (need_new) begin
            ci = int'($urandom_range(15));
            cur_pc = pool[ci];
            if (ci >= 12) cur_tk = ($urandom_range(7) != 0);
            else          cur_tk = ((cnt[ci] % (ci % 4 + 2)) != (ci % 4 + 1));
            cnt[ci]++;
         end
         um = has_p && (p_pred != p_tk);
         pv = !um;
         step(pv, cur_pc, has_p, p_pc, p_tk, p_l, p_g, um, p_gh, fixed);
         fixed = um;
         if (pv) begin
            has_p = 1; p_pc = cur_pc; p_tk = cur_tk; p_pred = e_tk[0];
            p_l = e_loc[0]; p_g = e_glb[0]; p_gh = e_gh; need_new = 1;
         end else begin
            has_p = 0; need_new = 0;
         end
      end

      // R1: a second reset clears the trained state
      do_reset();
      step(1, pool[0], 0, 0, 0, 0, 0, 0, 0, 0);
      chk("R1 re-reset history", d_gh, 0);
      chk("R1 re-reset chooser", d_sel, 0);
      chk("R1 re-reset global", d_glb, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule